// File: doc/BRIEF.md
# Polled Receive Link Master

This block is the link-layer end of a shared receive bus that serves several PHY ports. Each cycle it drives one port number on a poll address and moves to the next port, wrapping at the last. A port answers on a single cell-available line two clock edges later. The block keeps one ready flag per port and updates it from each answer.

Among the ready ports it picks one in round-robin order. It drives that port on a separate select address and raises the receive enable. While a cell streams in, polling goes on, so the next port is already known when the current cell ends. Moving from one cell to the next costs a single enable-low cycle.

Bytes arrive two cycles after the enable that requested them. They are gathered into fixed-length cells, with the start-of-cell marker used to check framing. Each complete cell is then streamed out with a valid strobe, a last strobe and the port it came from. A framing fault drops the partial cell and raises a sticky error flag.

Top module: `rxp_master`

## Requirements
- R1: While reset is asserted, `rx_en`, `out_valid` and `cell_err` are 0 and `poll_addr` is 0.
- R2: After reset, `poll_addr` counts up by one each cycle and wraps from NPORTS-1 to 0. The `cell_avail` value sampled at an edge belongs to the port that `poll_addr` showed in the cycle two edges earlier. Only a port that answered 1 can be selected.
- R3: `rx_sel` is placed in a cycle in which `rx_en` is 0, and `rx_en` rises in the following cycle. `rx_sel` does not change while `rx_en` is 1.
- R4: Each enable run lasts exactly CELL_BYTES cycles. When another port is ready at the end of a run, the next run starts after exactly one cycle with `rx_en` low.
- R5: The next port is the first ready port in rising cyclic order, starting one past the port served last. A port whose latest poll answer was 0 is skipped.
- R6: A byte, with its marker `rx_soc`, is taken only at an edge where `rx_en` was 1 in the cycle two edges earlier. The byte then belongs to the port `rx_sel` showed in that same cycle. Bytes and markers at any other edge have no effect.
- R7: A complete cell leaves on `out_data` as CELL_BYTES bytes in consecutive cycles with `out_valid` set. Byte 0 is the byte that carried the marker. `out_last` is 1 only on the final byte, and `out_port` holds the source port for the whole cell.
- R8: A marker on a taken byte while a cell is partly gathered sets `cell_err`. The partial cell is never output, and that byte starts a new cell.
- R9: A taken byte without a marker when no cell is open sets `cell_err` and is dropped. No cell is output until a marked byte arrives.
- R10: `cell_err` stays 1 from the cycle after it is set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| poll_addr | output | PW | Port being polled this cycle |
| cell_avail | input | 1 | Poll answer for the port polled two cycles earlier |
| rx_sel | output | PW | Port selected for transfer |
| rx_en | output | 1 | Receive enable for the selected port |
| rx_data | input | DW | Received byte |
| rx_soc | input | 1 | Start-of-cell marker for `rx_data` |
| out_valid | output | 1 | Output byte valid |
| out_data | output | DW | Output cell byte |
| out_last | output | 1 | Final byte of the cell |
| out_port | output | PW | Source port of the cell being output |
| cell_err | output | 1 | Sticky framing error |

## Verification
The bench uses NPORTS = 4 and CELL_BYTES = 52. With these values a poll lap takes four cycles, so each port is polled thirteen times during one cell. That puts stale answers from the port being served, and from ports that still hold a second cell, within reach. Four ports give full round-robin laps and a lap with two empty ports skipped. In the cycles outside the enable window the bench drives random bytes with the marker set, so the acceptance window is tested on every idle cycle.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_XFER = 2'd2
  } sel_state_e;
endpackage

// File: rtl/rxp_poll.sv
module rxp_poll #(
  parameter int NPORTS = 4,
  parameter int PW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PW-1:0]     poll_addr,
  input  logic              cell_avail,
  input  logic              mask_en,
  input  logic [PW-1:0]     mask_port,
  input  logic              clr_en,
  input  logic [PW-1:0]     clr_port,
  output logic [NPORTS-1:0] ready
);
  logic [PW-1:0]     addr_q, addr_n, pa1_q, pa2_q;
  logic              pv1_q, pv2_q;
  logic [NPORTS-1:0] rdy_q, rdy_n;
  logic              upd_en;

  assign upd_en = pv2_q && !(mask_en && (pa2_q == mask_port));

  always_comb begin
    addr_n = (addr_q == PW'(NPORTS - 1)) ? '0 : addr_q + 1'b1;
  end

  always_comb begin
    rdy_n = rdy_q;
    if (upd_en) rdy_n[pa2_q] = cell_avail;
    if (clr_en) rdy_n[clr_port] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pa1_q  <= '0;
      pa2_q  <= '0;
      pv1_q  <= 1'b0;
      pv2_q  <= 1'b0;
      rdy_q  <= '0;
    end else begin
      addr_q <= addr_n;
      pa1_q  <= addr_q;
      pa2_q  <= pa1_q;
      pv1_q  <= 1'b1;
      pv2_q  <= pv1_q;
      rdy_q  <= rdy_n;
    end
  end

  assign poll_addr = addr_q;
  assign ready     = rdy_q;

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !rdy_q[$past(clr_port)]); // R5
endmodule

// File: rtl/rxp_rr_pick.sv
module rxp_rr_pick #(
  parameter int NPORTS = 4,
  parameter int PW     = 2
) (
  input  logic [NPORTS-1:0] ready,
  input  logic [PW-1:0]     last,
  output logic              any,
  output logic [PW-1:0]     port
);
  int idx;

  always_comb begin
    any  = 1'b0;
    port = '0;
    idx  = 0;
    for (int i = NPORTS; i >= 1; i--) begin
      idx = (int'(last) + i) % NPORTS;
      if (ready[idx[PW-1:0]]) begin
        any  = 1'b1;
        port = idx[PW-1:0];
      end
    end
  end
endmodule

// File: rtl/rxp_cell_asm.sv
module rxp_cell_asm #(
  parameter int CELL_BYTES = 52,
  parameter int DW         = 8,
  parameter int PW         = 2,
  parameter int CW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_in,
  input  logic [PW-1:0] sel_in,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_soc,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic [PW-1:0] out_port,
  output logic          cell_err
);
  localparam logic [CW-1:0] LAST = CW'(CELL_BYTES - 1);

  logic          d1_q, d2_q;
  logic [PW-1:0] s1_q, s2_q;
  logic [CW-1:0] cnt_q, cnt_n, widx, ridx_q, ridx_n;
  logic [PW-1:0] port_q, port_n;
  logic          wr, bad, done;
  logic          wbank_q, wbank_n, rbank_q, rbank_n, drain_q, drain_n;
  logic          err_q, err_n;
  logic [DW-1:0] mem_q [2][CELL_BYTES];
  logic [PW-1:0] bport_q [2];

  // byte framing
  always_comb begin
    cnt_n  = cnt_q;
    port_n = port_q;
    wr     = 1'b0;
    widx   = cnt_q;
    bad    = 1'b0;
    done   = 1'b0;
    if (d2_q) begin
      if (rx_soc) begin
        bad    = (cnt_q != '0);
        wr     = 1'b1;
        widx   = '0;
        cnt_n  = CW'(1);
        port_n = s2_q;
      end else if (cnt_q == '0) begin
        bad = 1'b1;
      end else begin
        wr = 1'b1;
        if (cnt_q == LAST) begin
          cnt_n = '0;
          done  = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  // output drain
  always_comb begin
    drain_n = drain_q;
    ridx_n  = ridx_q;
    rbank_n = rbank_q;
    wbank_n = wbank_q;
    if (done) begin
      drain_n = 1'b1;
      ridx_n  = '0;
      rbank_n = wbank_q;
      wbank_n = ~wbank_q;
    end else if (drain_q) begin
      if (ridx_q == LAST) drain_n = 1'b0;
      else                ridx_n  = ridx_q + 1'b1;
    end
    err_n = err_q | bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1_q    <= 1'b0;
      d2_q    <= 1'b0;
      s1_q    <= '0;
      s2_q    <= '0;
      cnt_q   <= '0;
      port_q  <= '0;
      wbank_q <= 1'b0;
      rbank_q <= 1'b0;
      drain_q <= 1'b0;
      ridx_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      d1_q    <= en_in;
      d2_q    <= d1_q;
      s1_q    <= sel_in;
      s2_q    <= s1_q;
      cnt_q   <= cnt_n;
      port_q  <= port_n;
      wbank_q <= wbank_n;
      rbank_q <= rbank_n;
      drain_q <= drain_n;
      ridx_q  <= ridx_n;
      err_q   <= err_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr)   mem_q[wbank_q][widx] <= rx_data;
    if (done) bport_q[wbank_q]     <= port_q;
  end

  assign out_valid = drain_q;
  assign out_data  = mem_q[rbank_q][ridx_q];
  assign out_last  = drain_q && (ridx_q == LAST);
  assign out_port  = bport_q[rbank_q];
  assign cell_err  = err_q;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!drain_q || ridx_q == LAST)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R10
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid || done || $past(done)); // R7
endmodule

// File: rtl/rxp_master.sv
module rxp_master
  import rxp_pkg::*;
#(
  parameter int NPORTS     = 4,
  parameter int CELL_BYTES = 52,
  parameter int DW         = 8,
  parameter int PW         = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] poll_addr,
  input  logic          cell_avail,
  output logic [PW-1:0] rx_sel,
  output logic          rx_en,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_soc,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic [PW-1:0] out_port,
  output logic          cell_err
);
  localparam int CW = $clog2(CELL_BYTES);
  localparam logic [CW-1:0] LAST = CW'(CELL_BYTES - 1);

  logic [1:0]        rs_q;
  logic              rst_i;
  sel_state_e        state_q, state_n;
  logic [PW-1:0]     sel_q, sel_n, pick_port;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              take, pick_any;
  logic [NPORTS-1:0] ready_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  rxp_poll #(.NPORTS(NPORTS), .PW(PW)) u_poll (
    .clk(clk), .rst_n(rst_i), .poll_addr(poll_addr), .cell_avail(cell_avail),
    .mask_en(state_q != ST_IDLE), .mask_port(sel_q),
    .clr_en(take), .clr_port(pick_port), .ready(ready_vec)
  );

  rxp_rr_pick #(.NPORTS(NPORTS), .PW(PW)) u_pick (
    .ready(ready_vec), .last(sel_q), .any(pick_any), .port(pick_port)
  );

  always_comb begin
    state_n = state_q;
    sel_n   = sel_q;
    cnt_n   = cnt_q;
    take    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (pick_any) begin
          take    = 1'b1;
          sel_n   = pick_port;
          state_n = ST_ARM;
        end
      end
      ST_ARM: begin
        cnt_n   = '0;
        state_n = ST_XFER;
      end
      ST_XFER: begin
        if (cnt_q == LAST) begin
          if (pick_any) begin
            take    = 1'b1;
            sel_n   = pick_port;
            state_n = ST_ARM;
          end else begin
            state_n = ST_IDLE;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      sel_q   <= PW'(NPORTS - 1);
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      sel_q   <= sel_n;
      cnt_q   <= cnt_n;
    end
  end

  assign rx_en  = (state_q == ST_XFER);
  assign rx_sel = sel_q;

  rxp_cell_asm #(.CELL_BYTES(CELL_BYTES), .DW(DW), .PW(PW), .CW(CW)) u_asm (
    .clk(clk), .rst_n(rst_i), .en_in(rx_en), .sel_in(rx_sel),
    .rx_data(rx_data), .rx_soc(rx_soc),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_port(out_port), .cell_err(cell_err)
  );

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    rx_en |-> $stable(rx_sel)); // R3
  AST_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(rx_en) |-> $past(cnt_q) == LAST); // R4
  AST_PICK_READY: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_ARM) |-> |($past(ready_vec) & (NPORTS'(1) << sel_q))); // R5
endmodule

// File: tb/tb_rxp_master.sv
module tb_rxp_master;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 4;
  localparam int CELL = 52;
  localparam int PW   = 2;

  logic clk, rst_n;
  logic [PW-1:0] poll_addr, rx_sel, out_port;
  logic cell_avail, rx_en, rx_soc, out_valid, out_last, cell_err;
  logic [7:0] rx_data, out_data;

  int checks = 0, errors = 0;

  logic [8:0] phy_q [NP][$];
  logic [7:0] exp_q [NP][$];
  int cells_left [NP];
  int pos [NP];
  int order_log [$];
  int run_log [$];
  int gap_log [$];
  int sel_bad = 0;

  rxp_master #(.NPORTS(NP), .CELL_BYTES(CELL), .DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .poll_addr(poll_addr), .cell_avail(cell_avail),
    .rx_sel(rx_sel), .rx_en(rx_en), .rx_data(rx_data), .rx_soc(rx_soc),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_port(out_port), .cell_err(cell_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push_cell(input int p, input int seed, input int kind);
    for (int i = 0; i < CELL; i++) begin
      logic [7:0] d;
      logic s;
      d = 8'(seed + i * 3);
      s = (kind == 0 && i == 0) || (kind == 1 && (i == 0 || i == 20));
      phy_q[p].push_back({s, d});
      if (kind == 0) exp_q[p].push_back(d);
    end
    cells_left[p]++;
  endtask

  function automatic bit busy();
    bit b;
    b = rx_en || out_valid;
    for (int p = 0; p < NP; p++)
      if (phy_q[p].size() != 0 || exp_q[p].size() != 0) b = 1'b1;
    return b;
  endfunction

  task automatic wait_idle();
    int quiet;
    quiet = 0;
    while (quiet < 30) begin
      @(negedge clk);
      if (busy()) quiet = 0;
      else quiet++;
    end
  endtask

  task automatic clear_logs();
    order_log.delete();
    run_log.delete();
    gap_log.delete();
    sel_bad = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_en == 1'b0, "R1", "rx_en in reset", int'(rx_en), 0);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(cell_err == 1'b0, "R1", "cell_err in reset", int'(cell_err), 0);
    chk(poll_addr == '0, "R1", "poll_addr in reset", int'(poll_addr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // PHY model: answers polls and sends bytes two cycles after the request
  initial begin
    logic en_h [2];
    logic [PW-1:0] sel_h [2];
    logic [PW-1:0] pa_h [2];
    logic [PW-1:0] prev_sel;
    int run, gap;
    en_h = '{1'b0, 1'b0};
    sel_h = '{'0, '0};
    pa_h = '{'0, '0};
    prev_sel = '0;
    run = 0;
    gap = 0;
    for (int p = 0; p < NP; p++) begin
      cells_left[p] = 0;
      pos[p] = 0;
    end
    cell_avail = 1'b0;
    rx_data = 8'h00;
    rx_soc = 1'b0;
    forever begin
      @(negedge clk);
      cell_avail = (cells_left[int'(pa_h[1])] > 0);
      if (en_h[1]) begin
        int p;
        p = int'(sel_h[1]);
        if (phy_q[p].size() > 0) begin
          logic [8:0] b;
          b = phy_q[p].pop_front();
          if (pos[p] % CELL == 0) cells_left[p]--;
          pos[p]++;
          rx_data = b[7:0];
          rx_soc = b[8];
        end else begin
          rx_data = 8'($urandom);
          rx_soc = 1'b0;
        end
      end else begin
        rx_data = 8'($urandom);
        rx_soc = 1'b1; // R6: marker outside the window must be ignored
      end
      en_h[1] = en_h[0];
      en_h[0] = rx_en;
      sel_h[1] = sel_h[0];
      sel_h[0] = rx_sel;
      pa_h[1] = pa_h[0];
      pa_h[0] = poll_addr;
      if (rst_n && rx_en) begin
        if (run == 0) begin
          gap_log.push_back(gap);
          gap = 0;
        end else if (rx_sel != prev_sel) begin
          sel_bad++;
        end
        run++;
      end else begin
        if (run > 0) begin
          run_log.push_back(run);
          run = 0;
        end
        gap++;
      end
      prev_sel = rx_sel;
    end
  end

  // Scoreboard monitor
  initial begin
    int bi, cur;
    bi = 0;
    cur = 0;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (bi == 0) cur = int'(out_port);
        chk(int'(out_port) == cur, "R7", "port tag held", int'(out_port), cur);
        if (exp_q[int'(out_port)].size() == 0) begin
          chk(1'b0, "R7", "unexpected byte from port", int'(out_port), -1);
        end else begin
          logic [7:0] e;
          e = exp_q[int'(out_port)].pop_front();
          chk(out_data == e, "R7", "cell byte", int'(out_data), int'(e));
        end
        chk(out_last == (bi == CELL - 1), "R7", "last strobe", int'(out_last), int'(bi == CELL - 1));
        bi++;
        if (out_last || bi == CELL) begin
          order_log.push_back(cur);
          bi = 0;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int prev;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    do_reset();

    // R2: poll address sequence
    prev = int'(poll_addr);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(int'(poll_addr) == (prev + 1) % NP, "R2", "poll step", int'(poll_addr), (prev + 1) % NP);
      prev = int'(poll_addr);
    end

    // Scenario A: two cells on every port
    clear_logs();
    for (int p = 0; p < NP; p++) begin
      push_cell(p, 16 * p + 1, 0);
      push_cell(p, 16 * p + 101, 0);
    end
    wait_idle();
    chk(order_log.size() == 8, "R7", "cells out A", order_log.size(), 8);
    for (int i = 1; i < order_log.size(); i++)
      chk(order_log[i] == (order_log[0] + i) % NP, "R5", "round robin order",
          order_log[i], (order_log[0] + i) % NP);
    for (int i = 0; i < run_log.size(); i++)
      chk(run_log[i] == CELL, "R4", "enable run length", run_log[i], CELL);
    for (int i = 1; i < gap_log.size(); i++)
      chk(gap_log[i] == 1, "R4", "gap between cells", gap_log[i], 1);
    chk(sel_bad == 0, "R3", "select change while enabled", sel_bad, 0);
    chk(cell_err == 1'b0, "R6", "no error from ignored markers", int'(cell_err), 0);

    // Scenario B: ports 1 and 3 only, empty ports skipped
    clear_logs();
    push_cell(1, 7, 0);
    push_cell(3, 77, 0);
    push_cell(1, 9, 0);
    push_cell(3, 99, 0);
    wait_idle();
    chk(order_log.size() == 4, "R5", "cells out B", order_log.size(), 4);
    for (int i = 0; i < order_log.size(); i++) begin
      chk(order_log[i] == 1 || order_log[i] == 3, "R5", "skip empty ports", order_log[i], 1);
      if (i > 0) chk(order_log[i] != order_log[i - 1], "R5", "alternate ports", order_log[i], 4 - order_log[i - 1]);
    end
    for (int i = 1; i < gap_log.size(); i++)
      chk(gap_log[i] == 1, "R4", "gap B", gap_log[i], 1);
    chk(cell_err == 1'b0, "R2", "poll answers matched to ports", int'(cell_err), 0);

    // Scenario D: marker in the middle of a cell
    clear_logs();
    push_cell(2, 40, 1);
    push_cell(2, 140, 0);
    wait_idle();
    chk(cell_err == 1'b1, "R8", "error on mid marker", int'(cell_err), 1);
    chk(order_log.size() == 1, "R8", "partial dropped", order_log.size(), 1);
    clear_logs();
    push_cell(0, 55, 0);
    wait_idle();
    chk(cell_err == 1'b1, "R10", "error held", int'(cell_err), 1);
    chk(order_log.size() == 1, "R10", "traffic continues", order_log.size(), 1);

    do_reset();
    chk(cell_err == 1'b0, "R10", "reset clears error", int'(cell_err), 0);

    // Scenario E: missing marker
    clear_logs();
    push_cell(1, 200, 2);
    push_cell(1, 30, 0);
    wait_idle();
    chk(cell_err == 1'b1, "R9", "error on missing marker", int'(cell_err), 1);
    chk(order_log.size() == 1, "R9", "unmarked bytes dropped", order_log.size(), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule